// File: doc/BRIEF.md
# USB Control Endpoint State Controller

This block holds the control and status bits of a USB device's default control endpoint. It raises one interrupt line for them, and it tracks which phase of a control transfer the endpoint is in: idle, receiving an OUT data phase, or sending an IN data phase. The packet engine reports four kinds of event as one-cycle strobes: a packet landed in the FIFO, a transmitted packet was acknowledged, a stall handshake was sent, and a control transfer ended early. Firmware reads the status word and writes command bits to it.

The block does not leave the firmware to sort out interrupt causes. It reports the most urgent pending cause as a small code, in a fixed order. Illegal terminations come first. A pending stall or early-end flag forces the phase back to idle before any data-phase command can act. When firmware acknowledges a received setup packet, the decoded request class picks the next phase.

Top module: `usb_ep0_ctrl`

## Requirements
- R1: After reset the status word reads 0, the phase is IDLE (code 0), the cause code is 0 and the interrupt is low.
- R2: A packet-received strobe sets status bit 0 on the next cycle. Writing 1 to bit 6 clears bit 0. Bit 6 always reads 0. When a strobe and a clear arrive in the same cycle, the strobe wins.
- R3: Writing 1 to bit 1 sets transmit-ready. A transmit-acknowledge strobe clears it, and this strobe wins over a same-cycle write. The strobe also makes the transmit-done cause pending. That cause is dropped by a write with bit 1 or bit 3 set.
- R4: A stall strobe sets status bit 2. Writing 1 to bit 2 clears it. A strobe in the same cycle as the clear wins.
- R5: An early-end strobe sets status bit 4. Writing 1 to bit 4 clears it. A strobe in the same cycle as the clear wins.
- R6: While bit 2 or bit 4 is set, the phase is forced to IDLE on the next cycle, whatever is written.
- R7: In IDLE, a write of bit 6 while bit 0 is set chooses the next phase from the request class. Class 0 (no data) stays in IDLE, class 1 (OUT data) moves to RX (phase code 1), and class 2 (IN data) moves to TX (phase code 2). Class 3 is treated as no data.
- R8: In RX, a write with bit 3 set returns the phase to IDLE. A write of bit 6 without bit 3 leaves the phase in RX.
- R9: In TX, a write with bit 3 set returns the phase to IDLE. A write of bit 1 alone leaves the phase in TX.
- R10: Writing 1 to bit 3 sets data-end. Data-end clears on the first clock edge at which it is already set and the phase is already IDLE, unless a new write of bit 3 comes in that same cycle.
- R11: The cause code is 1 for stall, 2 for early end, 3 for packet received and 4 for transmit done. The lowest pending unmasked code is reported. A mask bit i set to 1 hides cause code i+1.
- R12: The interrupt is high in exactly the cycles in which the cause code is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_rx_pkt_i | input | 1 | Strobe: packet written to FIFO |
| ev_tx_ack_i | input | 1 | Strobe: transmitted packet acknowledged |
| ev_stall_i | input | 1 | Strobe: stall handshake sent |
| ev_early_end_i | input | 1 | Strobe: control transfer ended early |
| setup_class_i | input | 2 | Decoded request class: 0 none, 1 OUT, 2 IN |
| wr_en_i | input | 1 | Firmware write strobe |
| wr_data_i | input | DATA_W | Firmware write data |
| irq_mask_i | input | 4 | Cause mask, bit i hides code i+1 |
| csr_o | output | DATA_W | Status word |
| phase_o | output | 2 | Phase: 0 IDLE, 1 RX, 2 TX |
| cause_o | output | 3 | Highest-priority pending cause code |
| irq_o | output | 1 | Endpoint interrupt level |

## Verification
A wrong flag value shows on the status word one cycle after the event or write that caused it. In the same cycle it usually also shows on the cause code and the interrupt, because both are decoded from the flags without a register. A wrong phase is seen only indirectly at first, as a later command that moves or fails to move the phase. For that reason the bench compares the phase output on every clock against a model, so a divergence is reported in the cycle after the edge that caused it. A missed abort or a stuck data-end flag is therefore caught within two cycles.

// File: rtl/usb_ep0_pkg.sv
package usb_ep0_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_RX   = 2'd1,
      PH_TX   = 2'd2
   } ep0_phase_e;

   // status word bit positions
   localparam int BIT_RXRDY = 0;
   localparam int BIT_TXRDY = 1;
   localparam int BIT_STALL = 2;
   localparam int BIT_DEND  = 3;
   localparam int BIT_EEND  = 4;
   localparam int BIT_SERV  = 6;
   localparam int MIN_W     = 8;

   // pending-cause vector index (index + 1 = cause code)
   localparam int CI_STALL = 0;
   localparam int CI_EEND  = 1;
   localparam int CI_RX    = 2;
   localparam int CI_TXD   = 3;
   localparam int NCAUSE   = 4;
   localparam int CODE_W   = $clog2(NCAUSE + 1);

   localparam logic [1:0] CLS_NONE = 2'd0;
   localparam logic [1:0] CLS_OUT  = 2'd1;
   localparam logic [1:0] CLS_IN   = 2'd2;
endpackage

// File: rtl/ep0_flag_bit.sv
module ep0_flag_bit #(
   parameter bit HW_LEVEL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hw_ev,
   input  logic sw_ev,
   output logic q
);
   // hardware event wins over a software action in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= 1'b0;
      else if (hw_ev)  q <= HW_LEVEL;
      else if (sw_ev)  q <= ~HW_LEVEL;
   end
endmodule

// File: rtl/ep0_cause_arb.sv
module ep0_cause_arb #(
   parameter int NCAUSE = 4,
   parameter int CODE_W = 3
) (
   input  logic [NCAUSE-1:0] pend,
   input  logic [NCAUSE-1:0] mask,
   output logic [CODE_W-1:0] code
);
   initial begin
      if ((1 << CODE_W) <= NCAUSE) $error("cause code too narrow");
   end

   // lowest index pending and unmasked wins
   always_comb begin
      code = '0;
      for (int i = NCAUSE - 1; i >= 0; i--) begin
         if (pend[i] && !mask[i]) code = CODE_W'(i + 1);
      end
   end
endmodule

// File: rtl/ep0_phase_fsm.sv
module ep0_phase_fsm
   import usb_ep0_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       abort,
   input  logic       wr_dend,
   input  logic       wr_serv,
   input  logic       rx_rdy,
   input  logic [1:0] setup_class,
   output ep0_phase_e phase,
   output logic       dend
);
   ep0_phase_e nxt;

   always_comb begin
      nxt = phase;
      if (abort) begin
         nxt = PH_IDLE;
      end else begin
         unique case (phase)
            PH_IDLE: if (wr_serv && rx_rdy) begin
               unique case (setup_class)
                  CLS_OUT: nxt = PH_RX;
                  CLS_IN:  nxt = PH_TX;
                  default: nxt = PH_IDLE;
               endcase
            end
            PH_RX:   if (wr_dend) nxt = PH_IDLE;
            PH_TX:   if (wr_dend) nxt = PH_IDLE;
            default: nxt = PH_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         dend  <= 1'b0;
      end else begin
         phase <= nxt;
         if (wr_dend)               dend <= 1'b1;
         else if (phase == PH_IDLE) dend <= 1'b0;
      end
   end
endmodule

// File: rtl/usb_ep0_ctrl.sv
module usb_ep0_ctrl
   import usb_ep0_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_rx_pkt_i,
   input  logic              ev_tx_ack_i,
   input  logic              ev_stall_i,
   input  logic              ev_early_end_i,
   input  logic [1:0]        setup_class_i,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [3:0]        irq_mask_i,
   output logic [DATA_W-1:0] csr_o,
   output logic [1:0]        phase_o,
   output logic [2:0]        cause_o,
   output logic              irq_o
);
   generate
      if (DATA_W < MIN_W) begin : g_bad_width
         initial $error("DATA_W must hold the status bits");
      end
      if (NCAUSE != 4 || CODE_W != 3) begin : g_bad_cause
         initial $error("cause layout does not match ports");
      end
   endgenerate

   logic w_serv, w_txrdy, w_stall, w_dend, w_eend;
   assign w_serv  = wr_en_i & wr_data_i[BIT_SERV];
   assign w_txrdy = wr_en_i & wr_data_i[BIT_TXRDY];
   assign w_stall = wr_en_i & wr_data_i[BIT_STALL];
   assign w_dend  = wr_en_i & wr_data_i[BIT_DEND];
   assign w_eend  = wr_en_i & wr_data_i[BIT_EEND];

   logic [NCAUSE-1:0] set_ev, clr_ev, pend;
   always_comb begin
      set_ev           = '0;
      clr_ev           = '0;
      set_ev[CI_STALL] = ev_stall_i;
      clr_ev[CI_STALL] = w_stall;
      set_ev[CI_EEND]  = ev_early_end_i;
      clr_ev[CI_EEND]  = w_eend;
      set_ev[CI_RX]    = ev_rx_pkt_i;
      clr_ev[CI_RX]    = w_serv;
      set_ev[CI_TXD]   = ev_tx_ack_i;
      clr_ev[CI_TXD]   = w_txrdy | w_dend;
   end

   genvar gi;
   generate
      for (gi = 0; gi < NCAUSE; gi++) begin : g_flag
         ep0_flag_bit #(.HW_LEVEL(1'b1)) u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .hw_ev (set_ev[gi]),
            .sw_ev (clr_ev[gi]),
            .q     (pend[gi])
         );
      end
   endgenerate

   logic tx_rdy;
   ep0_flag_bit #(.HW_LEVEL(1'b0)) u_txrdy (
      .clk   (clk),
      .rst_n (rst_n),
      .hw_ev (ev_tx_ack_i),
      .sw_ev (w_txrdy),
      .q     (tx_rdy)
   );

   ep0_phase_e phase;
   logic       dend;
   ep0_phase_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .abort       (pend[CI_STALL] | pend[CI_EEND]),
      .wr_dend     (w_dend),
      .wr_serv     (w_serv),
      .rx_rdy      (pend[CI_RX]),
      .setup_class (setup_class_i),
      .phase       (phase),
      .dend        (dend)
   );

   logic [CODE_W-1:0] code;
   ep0_cause_arb #(.NCAUSE(NCAUSE), .CODE_W(CODE_W)) u_arb (
      .pend (pend),
      .mask (irq_mask_i),
      .code (code)
   );

   always_comb begin
      csr_o            = '0;
      csr_o[BIT_RXRDY] = pend[CI_RX];
      csr_o[BIT_TXRDY] = tx_rdy;
      csr_o[BIT_STALL] = pend[CI_STALL];
      csr_o[BIT_DEND]  = dend;
      csr_o[BIT_EEND]  = pend[CI_EEND];
   end

   assign phase_o = phase;
   assign cause_o = code;

   generate
      if (IRQ_REG) begin : g_irq_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_o <= 1'b0;
            else        irq_o <= |code;
         end
      end else begin : g_irq_comb
         assign irq_o = |code;
      end
   endgenerate
endmodule

// File: rtl/ep0_ctrl_checker.sv
module ep0_ctrl_checker #(
   parameter int DATA_W  = 8,
   parameter bit IRQ_REG = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ev_rx_pkt_i,
   input logic              ev_tx_ack_i,
   input logic              ev_stall_i,
   input logic              ev_early_end_i,
   input logic              wr_en_i,
   input logic [DATA_W-1:0] wr_data_i,
   input logic [3:0]        irq_mask_i,
   input logic [DATA_W-1:0] csr_o,
   input logic [1:0]        phase_o,
   input logic [2:0]        cause_o,
   input logic              irq_o
);
   assert_rx_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ev_rx_pkt_i |=> csr_o[0]);
   assert_serv_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !csr_o[6]);
   assert_tx_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ev_tx_ack_i |=> !csr_o[1]);
   assert_stall_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ev_stall_i |=> csr_o[2]);
   assert_eend_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ev_early_end_i |=> csr_o[4]);
   assert_abort_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_o[2] || csr_o[4]) |=> (phase_o == 2'd0));
   assert_rx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_o == 2'd1 && wr_en_i && wr_data_i[6] && !wr_data_i[3]
       && !csr_o[2] && !csr_o[4]) |=> (phase_o == 2'd1));
   assert_dend_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_o[3] && phase_o == 2'd0 && !(wr_en_i && wr_data_i[3])) |=> !csr_o[3]);
   assert_stall_first_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_o[2] && !irq_mask_i[0]) |-> (cause_o == 3'd1));
   assert_irq_level_R12: assert property (@(posedge clk) disable iff (!rst_n)
      IRQ_REG || (irq_o == (cause_o != 3'd0)));
endmodule

bind usb_ep0_ctrl ep0_ctrl_checker #(.DATA_W(DATA_W), .IRQ_REG(IRQ_REG)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .ev_rx_pkt_i    (ev_rx_pkt_i),
   .ev_tx_ack_i    (ev_tx_ack_i),
   .ev_stall_i     (ev_stall_i),
   .ev_early_end_i (ev_early_end_i),
   .wr_en_i        (wr_en_i),
   .wr_data_i      (wr_data_i),
   .irq_mask_i     (irq_mask_i),
   .csr_o          (csr_o),
   .phase_o        (phase_o),
   .cause_o        (cause_o),
   .irq_o          (irq_o)
);

// File: tb/tb_usb_ep0_ctrl.sv
`timescale 1ns/1ps
module tb_usb_ep0_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ev_rx = 1'b0, ev_tx = 1'b0, ev_st = 1'b0, ev_ee = 1'b0;
   logic [1:0] cls = 2'd0;
   logic       we = 1'b0;
   logic [7:0] wd = 8'd0;
   logic [3:0] msk = 4'd0;
   logic [7:0] csr;
   logic [1:0] ph;
   logic [2:0] cause;
   logic       irq;

   int errors = 0;
   int checks = 0;

   always #4 clk = ~clk;

   usb_ep0_ctrl dut (
      .clk(clk), .rst_n(rst_n),
      .ev_rx_pkt_i(ev_rx), .ev_tx_ack_i(ev_tx), .ev_stall_i(ev_st), .ev_early_end_i(ev_ee),
      .setup_class_i(cls), .wr_en_i(we), .wr_data_i(wd), .irq_mask_i(msk),
      .csr_o(csr), .phase_o(ph), .cause_o(cause), .irq_o(irq)
   );

   // behavioural reference model
   bit m_rx, m_tx, m_txd, m_st, m_ee, m_de;
   int m_ph;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_rx <= 0; m_tx <= 0; m_txd <= 0; m_st <= 0; m_ee <= 0; m_de <= 0; m_ph <= 0;
      end else begin
         m_rx  <= ev_rx ? 1'b1 : (we && wd[6]) ? 1'b0 : m_rx;
         m_tx  <= ev_tx ? 1'b0 : (we && wd[1]) ? 1'b1 : m_tx;
         m_txd <= ev_tx ? 1'b1 : (we && (wd[1] || wd[3])) ? 1'b0 : m_txd;
         m_st  <= ev_st ? 1'b1 : (we && wd[2]) ? 1'b0 : m_st;
         m_ee  <= ev_ee ? 1'b1 : (we && wd[4]) ? 1'b0 : m_ee;
         m_de  <= (we && wd[3]) ? 1'b1 : (m_ph == 0) ? 1'b0 : m_de;
         if (m_st || m_ee) m_ph <= 0;
         else if (m_ph == 0 && we && wd[6] && m_rx) m_ph <= (cls == 1) ? 1 : (cls == 2) ? 2 : 0;
         else if (m_ph != 0 && we && wd[3]) m_ph <= 0;
      end
   end

   function automatic int exp_cause();
      bit [3:0] p;
      p = {m_txd, m_rx, m_ee, m_st} & ~msk;
      for (int i = 0; i < 4; i++) if (p[i]) return i + 1;
      return 0;
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s at %0t actual=%0d expected=%0d", tag, $time, act, expv);
      end
   endtask

   logic started = 1'b0;
   always @(negedge clk) if (started && rst_n) begin
      chk(csr[0] == m_rx, "R2 rx-ready bit", csr[0], m_rx);
      chk(csr[6] == 1'b0, "R2 serviced bit reads 0", csr[6], 0);
      chk(csr[1] == m_tx, "R3 tx-ready bit", csr[1], m_tx);
      chk(csr[2] == m_st, "R4 stall bit", csr[2], m_st);
      chk(csr[4] == m_ee, "R5 early-end bit", csr[4], m_ee);
      chk(csr[3] == m_de, "R10 data-end bit", csr[3], m_de);
      chk(int'(ph) == m_ph, "R6 R7 R8 R9 phase", ph, m_ph);
      chk(int'(cause) == exp_cause(), "R11 cause code", cause, exp_cause());
      chk(irq == (exp_cause() != 0), "R12 irq level", irq, exp_cause() != 0);
   end

   // ev bits: [0] rx, [1] tx ack, [2] stall, [3] early end
   task automatic drive(input logic [3:0] ev, input logic w, input logic [7:0] d);
      @(posedge clk); #2;
      ev_rx = ev[0]; ev_tx = ev[1]; ev_st = ev[2]; ev_ee = ev[3];
      we = w; wd = d;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) drive(4'b0, 1'b0, 8'h00);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL R1 watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk);
      chk(csr == 8'h00 && ph == 2'd0 && cause == 3'd0 && irq == 1'b0,
          "R1 reset state", {csr, ph, cause, irq}, 0);
      started = 1'b1;

      // R7 IN request -> TX, R9 tx handling, R3 tx-done cause
      drive(4'b0001, 0, 8'h00); idle(2);
      cls = 2'd2; drive(4'b0, 1, 8'h40); idle(1);
      drive(4'b0, 1, 8'h02); idle(1);
      drive(4'b0010, 0, 8'h00); idle(2);
      drive(4'b0, 1, 8'h02); idle(1);
      drive(4'b0010, 1, 8'h02); idle(2);          // R3 event beats write
      drive(4'b0, 1, 8'h08); idle(4);             // R9 exit, R10 self-clear

      // R7 OUT request -> RX, R8 stay and exit
      drive(4'b0001, 0, 8'h00); idle(1);
      cls = 2'd1; drive(4'b0, 1, 8'h40); idle(1);
      drive(4'b0001, 0, 8'h00); idle(1);
      drive(4'b0, 1, 8'h40); idle(2);
      drive(4'b0001, 0, 8'h00); idle(1);
      drive(4'b0, 1, 8'h48); idle(4);

      // R7 no-data and class 3
      cls = 2'd0; drive(4'b0001, 0, 8'h00); drive(4'b0, 1, 8'h40); idle(2);
      cls = 2'd3; drive(4'b0001, 0, 8'h00); drive(4'b0, 1, 8'h40); idle(2);

      // R6 abort from RX on stall, R4 clear
      cls = 2'd1; drive(4'b0001, 0, 8'h00); drive(4'b0, 1, 8'h40); idle(1);
      drive(4'b0100, 0, 8'h00); idle(2);
      drive(4'b0, 1, 8'h04); idle(2);
      // R6 abort from TX on early end, R5 clear; writes ignored while pending
      cls = 2'd2; drive(4'b0001, 0, 8'h00); drive(4'b0, 1, 8'h40); idle(1);
      drive(4'b1000, 0, 8'h00); drive(4'b0001, 1, 8'h40); idle(1);
      drive(4'b0, 1, 8'h50); idle(2);

      // R11 priority: all causes, then clear one by one
      drive(4'b1111, 0, 8'h00); idle(1);
      drive(4'b0, 1, 8'h04); idle(1);
      drive(4'b0, 1, 8'h10); idle(1);
      drive(4'b0, 1, 8'h40); idle(1);
      drive(4'b0, 1, 8'h08); idle(3);

      // R4/R5/R2 event beats clear in the same cycle
      drive(4'b1101, 1, 8'h54); idle(2);
      // R11 masking
      msk = 4'b0001; idle(2);
      msk = 4'b0011; idle(2);
      msk = 4'b1111; idle(2);
      msk = 4'b0000; drive(4'b0, 1, 8'h54); idle(3);

      // R10 data-end written while idle clears after one cycle
      drive(4'b0, 1, 8'h08); idle(3);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule